// File: doc/BRIEF.md
# Prescaled 16-bit Timer/Counter with Compare Modes

This block is a 16-bit timer/counter for a small microcontroller, reached through a simple register bus. A free-running prescaler produces count enables. The counter advances on those enables and wraps at a TOP value, and the current mode picks that TOP. Two compare channels and an overflow event set sticky flags. Each flag raises an interrupt request when its mask bit is set and interrupts are globally enabled.

Software selects the clock divider and the mode through one control register. It loads the counter, compare values and top value directly. It clears flags by writing ones to the flag register. A bus write to the counter always wins over a count or clear that falls in the same cycle. Counting therefore resumes from the written value on the next enable.

In the two PWM modes, writes to the compare registers are held in a buffer. The active compare values take the buffered values when the counter wraps at TOP. In the other modes the active values follow every write at once.

Top module: `tmr16_unit`

## Requirements
- R1: A bus write to the count register (address 0) loads the written value at that clock edge, with no increment or clear applied in the same edge. The next enabled edge gives value+1, so writing 0x30 and reading back one edge later gives 0x31.
- R2: Clock-select code 1 (control bits [2:0]) advances the counter by one on every clock edge.
- R3: Clock-select code 0 stops the counter: its value holds across any number of edges.
- R4: Clock-select codes 2, 3, 4 and 5 divide by 8, 64, 256 and 1024. The prescaler is a 10-bit counter that starts at zero when reset ends and steps on every edge. An enabled edge is one where the prescaler's low 3, 6, 8 or 10 bits are all ones. Codes 6 and 7 stop the counter.
- R5: In mode 0 (control bits [5:4] = 0), an enabled edge at count 0xFFFF gives count 0 and sets the overflow flag (flag bit 0).
- R6: In mode 1, an enabled edge at a count equal to compare register A (address 1) returns the counter to 0. The overflow flag is not set.
- R7: An enabled edge that makes the count equal to the active compare value A sets flag bit 1. An enabled edge that makes it equal to compare value B (address 2) sets flag bit 2.
- R8: Interrupt outputs irqOvf, irqCmpA and irqCmpB follow flag bits 0, 1 and 2 ANDed with the same bits of the mask register (address 6) and with gieIn.
- R9: Writing the flag register (address 5) clears each flag whose data bit is 1. A flag set in the same edge stays set.
- R10: Mode 2 uses TOP = 0x3FF: an enabled edge at 0x3FF gives 0 and sets the overflow flag.
- R11: Mode 3 uses the top register (address 3) as TOP: an enabled edge at that value gives 0 and sets the overflow flag.
- R12: In modes 2 and 3, compare writes go to a buffer. The active compare values load from that buffer at an enabled edge where the counter wraps at TOP. In modes 0 and 1 a compare write takes effect at once.
- R13: After reset, the count, control, flag and mask registers read 0 and all interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 3 | Register address (0 count, 1 cmp A, 2 cmp B, 3 top, 4 control, 5 flags, 6 mask) |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr (compare addresses return the buffered value) |
| gieIn | input | 1 | Global interrupt enable |
| irqOvf | output | 1 | Overflow interrupt request |
| irqCmpA | output | 1 | Compare A interrupt request |
| irqCmpB | output | 1 | Compare B interrupt request |

## Verification
The bench writes the counter while it is running and reads it back before and after the next edge. A design that let the write-cycle increment through would read one higher. It lines up a flag-clear write with the exact wrap edge; a design that gives the clear priority would lose the overflow flag. It stalls a buffered compare write in mode 3 across a match that would hit the new value. A design without buffering would raise compare flag A early. It also predicts divide-by-256 enables from the edge count since reset, and checks that the clear-on-compare mode leaves the overflow flag alone.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  localparam int ADDR_W = 3;
  localparam int CS_W = 3;
  localparam int MODE_LSB = 4;
  localparam int FLAG_W = 3;

  localparam logic [ADDR_W-1:0] A_COUNT = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPB  = 3'd2;
  localparam logic [ADDR_W-1:0] A_TOP   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_FLAG  = 3'd5;
  localparam logic [ADDR_W-1:0] A_MASK  = 3'd6;

  typedef enum logic [1:0] {
    MODE_WRAP   = 2'd0,
    MODE_CLRA   = 2'd1,
    MODE_PWM10  = 2'd2,
    MODE_PWMTOP = 2'd3
  } mode_e;

  typedef struct packed {
    logic wrCount;
    logic wrCmpA;
    logic wrCmpB;
    logic wrTop;
    logic wrFlag;
    logic wrMask;
    logic step;
    logic wrapNow;
    logic setOvf;
    logic pwm;
  } strobe_t;
endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale
  import tmr16_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CS_W-1:0] csQ,
  output logic            tick
);
  localparam int NTAP = 4;

  logic [PRE_W-1:0] pre;
  logic [NTAP-1:0]  tapEn;

  always_ff @(posedge clk) begin
    if (rst) pre <= '0;
    else     pre <= pre + 1'b1;
  end

  // Divide taps 8, 64, 256, 1024: low bits of the divider all ones
  for (genvar k = 0; k < NTAP; k++) begin : gTap
    localparam int B = (k == 0) ? 3 : (k == 1) ? 6 : (k == 2) ? 8 : 10;
    assign tapEn[k] = &pre[B-1:0];
  end

  always_comb begin
    case (csQ)
      3'd1:    tick = 1'b1;
      3'd2:    tick = tapEn[0];
      3'd3:    tick = tapEn[1];
      3'd4:    tick = tapEn[2];
      3'd5:    tick = tapEn[3];
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/tmr16_ctrl.sv
module tmr16_ctrl
  import tmr16_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CS_W-1:0]   csIn,
  input  logic [1:0]        modeIn,
  input  logic              tick,
  input  logic              atTop,
  output strobe_t           st,
  output logic [CS_W-1:0]   csQ,
  output mode_e             modeQ
);
  logic wrCtl;

  assign wrCtl = busWe && (busAddr == A_CTL);

  always_ff @(posedge clk) begin
    if (rst) begin
      csQ   <= '0;
      modeQ <= MODE_WRAP;
    end else if (wrCtl) begin
      csQ   <= csIn;
      modeQ <= mode_e'(modeIn);
    end
  end

  always_comb begin
    st.wrCount = busWe && (busAddr == A_COUNT);
    st.wrCmpA  = busWe && (busAddr == A_CMPA);
    st.wrCmpB  = busWe && (busAddr == A_CMPB);
    st.wrTop   = busWe && (busAddr == A_TOP);
    st.wrFlag  = busWe && (busAddr == A_FLAG);
    st.wrMask  = busWe && (busAddr == A_MASK);
    // a counter write consumes the enable of its own cycle
    st.step    = tick && !st.wrCount;
    st.wrapNow = st.step && atTop;
    st.setOvf  = st.wrapNow && (modeQ != MODE_CLRA);
    st.pwm     = (modeQ == MODE_PWM10) || (modeQ == MODE_PWMTOP);
  end
endmodule

// File: rtl/tmr16_datapath.sv
module tmr16_datapath
  import tmr16_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PWM_TOP = 1023
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_t           st,
  input  mode_e             modeQ,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] ctlRead,
  input  logic              gieIn,
  output logic              atTop,
  output logic [DATA_W-1:0] busRdata,
  output logic [FLAG_W-1:0] irqVec,
  output logic [DATA_W-1:0] countQ,
  output logic [FLAG_W-1:0] flagQ
);
  localparam int NCMP = 2;
  localparam logic [DATA_W-1:0] TOP_FIX = DATA_W'(PWM_TOP);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] topReg, topVal, nextCount;
  logic [DATA_W-1:0] cmpBufV [NCMP];
  logic [DATA_W-1:0] cmpActV [NCMP];
  logic [NCMP-1:0]   hit;
  logic [FLAG_W-1:0] maskQ, setVec, clrVec;

  always_comb begin
    case (modeQ)
      MODE_WRAP:  topVal = '1;
      MODE_CLRA:  topVal = cmpActV[0];
      MODE_PWM10: topVal = TOP_FIX;
      default:    topVal = topReg;
    endcase
  end

  assign atTop     = (countQ == topVal);
  assign nextCount = st.wrapNow ? '0 : countQ + ONE;

  always_ff @(posedge clk) begin
    if (rst)             countQ <= '0;
    else if (st.wrCount) countQ <= busWdata;
    else if (st.step)    countQ <= nextCount;
  end

  always_ff @(posedge clk) begin
    if (rst)           topReg <= '0;
    else if (st.wrTop) topReg <= busWdata;
  end

  for (genvar gi = 0; gi < NCMP; gi++) begin : gCmp
    logic              wrThis;
    logic [DATA_W-1:0] bufR, actR;

    assign wrThis = (gi == 0) ? st.wrCmpA : st.wrCmpB;

    always_ff @(posedge clk) begin
      if (rst) begin
        bufR <= '0;
        actR <= '0;
      end else begin
        if (wrThis) bufR <= busWdata;
        if (!st.pwm)         actR <= wrThis ? busWdata : bufR;
        else if (st.wrapNow) actR <= bufR;
      end
    end

    assign cmpBufV[gi] = bufR;
    assign cmpActV[gi] = actR;
    assign hit[gi]     = st.step && (nextCount == actR);
  end

  assign setVec = {hit[1], hit[0], st.setOvf};
  assign clrVec = st.wrFlag ? busWdata[FLAG_W-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) flagQ <= '0;
    else     flagQ <= (flagQ & ~clrVec) | setVec;
  end

  always_ff @(posedge clk) begin
    if (rst)            maskQ <= '0;
    else if (st.wrMask) maskQ <= busWdata[FLAG_W-1:0];
  end

  assign irqVec = flagQ & maskQ & {FLAG_W{gieIn}};

  always_comb begin
    case (busAddr)
      A_COUNT: busRdata = countQ;
      A_CMPA:  busRdata = cmpBufV[0];
      A_CMPB:  busRdata = cmpBufV[1];
      A_TOP:   busRdata = topReg;
      A_CTL:   busRdata = ctlRead;
      A_FLAG:  busRdata = DATA_W'(flagQ);
      A_MASK:  busRdata = DATA_W'(maskQ);
      default: busRdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr16_unit.sv
module tmr16_unit
  import tmr16_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PRE_W   = 10,
  parameter int PWM_TOP = 1023
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              gieIn,
  output logic              irqOvf,
  output logic              irqCmpA,
  output logic              irqCmpB
);
  strobe_t           st;
  logic [CS_W-1:0]   csQ;
  mode_e             modeQ;
  logic              tick, atTop;
  logic [DATA_W-1:0] ctlRead, countQ;
  logic [FLAG_W-1:0] irqVec, flagQ;

  assign ctlRead = (DATA_W'(modeQ) << MODE_LSB) | DATA_W'(csQ);

  tmr16_prescale #(.PRE_W(PRE_W)) uPre (
    .clk(clk), .rst(rst), .csQ(csQ), .tick(tick)
  );

  tmr16_ctrl uCtrl (
    .clk(clk), .rst(rst), .busWe(busWe), .busAddr(busAddr),
    .csIn(busWdata[CS_W-1:0]), .modeIn(busWdata[MODE_LSB+1:MODE_LSB]),
    .tick(tick), .atTop(atTop), .st(st), .csQ(csQ), .modeQ(modeQ)
  );

  tmr16_datapath #(.DATA_W(DATA_W), .PWM_TOP(PWM_TOP)) uDp (
    .clk(clk), .rst(rst), .st(st), .modeQ(modeQ), .busAddr(busAddr),
    .busWdata(busWdata), .ctlRead(ctlRead), .gieIn(gieIn), .atTop(atTop),
    .busRdata(busRdata), .irqVec(irqVec), .countQ(countQ), .flagQ(flagQ)
  );

  assign irqOvf  = irqVec[0];
  assign irqCmpA = irqVec[1];
  assign irqCmpB = irqVec[2];
endmodule

// File: rtl/tmr16_check.sv
module tmr16_check
  import tmr16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [CS_W-1:0]   csQ,
  input mode_e             modeQ,
  input logic [DATA_W-1:0] countQ,
  input logic [FLAG_W-1:0] flagQ
);
  logic cntWr, flgWr;
  assign cntWr = busWe && (busAddr == A_COUNT);
  assign flgWr = busWe && (busAddr == A_FLAG);

  AST_WRITE_OVERRIDES: assert property (@(posedge clk) disable iff (rst)
    cntWr |=> countQ == $past(busWdata)); // R1

  AST_DIV1_STEP: assert property (@(posedge clk) disable iff (rst)
    (csQ == 3'd1 && modeQ == MODE_WRAP && !cntWr && countQ != '1)
      |=> countQ == DATA_W'($past(countQ) + DATA_W'(1))); // R2

  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (csQ == 3'd0 && !cntWr) |=> $stable(countQ)); // R3

  AST_WRAP_SETS_OVF: assert property (@(posedge clk) disable iff (rst)
    (csQ == 3'd1 && modeQ == MODE_WRAP && !cntWr && countQ == '1)
      |=> (countQ == '0 && flagQ[0])); // R5

  AST_CLRA_NO_OVF: assert property (@(posedge clk) disable iff (rst)
    (modeQ == MODE_CLRA && !flagQ[0] && !flgWr) |=> !flagQ[0]); // R6
endmodule

bind tmr16_unit tmr16_check #(.DATA_W(DATA_W)) uChk (
  .clk(clk), .rst(rst), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
  .csQ(csQ), .modeQ(modeQ), .countQ(countQ), .flagQ(flagQ)
);

// File: tb/tmr16_unit_test.sv
`timescale 1ns/1ps
module tmr16_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busWe = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [15:0] busWdata = 16'h0;
  logic [15:0] busRdata;
  logic        gieIn = 1'b0;
  logic        irqOvf, irqCmpA, irqCmpB;

  int nChecks = 0;
  int nErr = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];
  event sampleEv;

  always #4 clk = ~clk;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  tmr16_unit uut (
    .clk(clk), .rst(rst), .busWe(busWe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .gieIn(gieIn), .irqOvf(irqOvf), .irqCmpA(irqCmpA),
    .irqCmpB(irqCmpB)
  );

  // monitor: pops expected items and compares against the outputs
  item_t       curItem;
  logic [15:0] actVal;
  always begin
    @(sampleEv);
    while (sbq.size() > 0) begin
      curItem = sbq.pop_front();
      actVal = (curItem.kind == 1) ? {13'b0, irqCmpB, irqCmpA, irqOvf} : busRdata;
      nChecks++;
      if (actVal !== curItem.exp) begin
        nErr++;
        $display("FAIL %s: actual %h expected %h", curItem.tag, actVal, curItem.exp);
      end
    end
  end

  task automatic busWrite(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expectReg(input logic [2:0] a, input logic [15:0] e, input string tag);
    busAddr = a;
    sbq.push_back('{0, e, tag});
    #1 ->sampleEv;
    #1;
  endtask

  task automatic expectIrq(input logic [2:0] e, input string tag);
    sbq.push_back('{1, {13'b0, e}, tag});
    #1 ->sampleEv;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    int nW, nEnd;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    gieIn = 1'b1;

    // R13 reset state
    expectReg(3'd0, 16'h0000, "R13 count");
    expectReg(3'd5, 16'h0000, "R13 flags");
    cycles(1);
    expectReg(3'd4, 16'h0000, "R13 ctl");
    expectReg(3'd6, 16'h0000, "R13 mask");
    expectIrq(3'b000, "R13 irq");

    // park compare values far away (mode 0, stopped: write-through)
    busWrite(3'd1, 16'h7000);
    busWrite(3'd2, 16'h7100);

    // R3 stopped counter holds
    busWrite(3'd0, 16'h0055);
    cycles(5);
    expectReg(3'd0, 16'h0055, "R3 stop");

    // R1 write overrides the count of its own cycle
    busWrite(3'd4, 16'h0001);
    busWrite(3'd0, 16'h0030);
    expectReg(3'd0, 16'h0030, "R1 write cycle");
    cycles(1);
    expectReg(3'd0, 16'h0031, "R1 next tick");

    // R2 divide by 1
    busWrite(3'd0, 16'h0100);
    cycles(10);
    expectReg(3'd0, 16'h010A, "R2 div1");

    // R4 divide by 256, phase from edges since reset
    busWrite(3'd4, 16'h0004);
    busWrite(3'd0, 16'h0000);
    nW = cyc;
    cycles(600);
    nEnd = cyc;
    expectReg(3'd0, 16'((nEnd / 256) - (nW / 256)), "R4 div256");
    busWrite(3'd4, 16'h0000);

    // R5 normal wrap sets overflow
    busWrite(3'd0, 16'hFFFE);
    busWrite(3'd5, 16'h0007);
    busWrite(3'd4, 16'h0001);
    cycles(1);
    expectReg(3'd0, 16'hFFFF, "R5 at top");
    expectReg(3'd5, 16'h0000, "R5 no flag yet");
    cycles(1);
    expectReg(3'd0, 16'h0000, "R5 wrapped");
    expectReg(3'd5, 16'h0001, "R5 ovf flag");

    // R9 flag set wins over same-edge clear
    busWrite(3'd5, 16'h0007);
    busWrite(3'd0, 16'hFFFE);
    busWrite(3'd5, 16'h0001);
    expectReg(3'd5, 16'h0001, "R9 set priority");
    busWrite(3'd4, 16'h0000);
    busWrite(3'd5, 16'h0007);
    expectReg(3'd5, 16'h0000, "R9 write-one clear");

    // R6 / R7 clear on compare A
    busWrite(3'd1, 16'h0011);
    busWrite(3'd0, 16'h0010);
    busWrite(3'd4, 16'h0011);
    cycles(1);
    expectReg(3'd0, 16'h0011, "R6 reach cmpA");
    expectReg(3'd5, 16'h0002, "R7 flag A");
    cycles(1);
    expectReg(3'd0, 16'h0000, "R6 cleared");
    expectReg(3'd5, 16'h0002, "R6 no ovf");

    // R7 compare B
    busWrite(3'd4, 16'h0000);
    busWrite(3'd1, 16'h7000);
    busWrite(3'd2, 16'h0021);
    busWrite(3'd0, 16'h0020);
    busWrite(3'd5, 16'h0007);
    busWrite(3'd4, 16'h0001);
    cycles(1);
    expectReg(3'd5, 16'h0004, "R7 flag B");
    busWrite(3'd4, 16'h0000);

    // R8 interrupt gating
    busWrite(3'd6, 16'h0004);
    expectIrq(3'b100, "R8 masked on");
    gieIn = 1'b0;
    expectIrq(3'b000, "R8 global off");
    gieIn = 1'b1;
    busWrite(3'd6, 16'h0002);
    expectIrq(3'b000, "R8 mask other");
    busWrite(3'd6, 16'h0000);
    expectIrq(3'b000, "R8 mask clear");

    // R10 fast PWM 10-bit
    busWrite(3'd4, 16'h0020);
    busWrite(3'd0, 16'h03FE);
    busWrite(3'd5, 16'h0007);
    busWrite(3'd4, 16'h0021);
    cycles(1);
    expectReg(3'd0, 16'h03FF, "R10 at top");
    cycles(1);
    expectReg(3'd0, 16'h0000, "R10 wrapped");
    expectReg(3'd5, 16'h0001, "R10 ovf");
    busWrite(3'd4, 16'h0020);

    // R11 fast PWM with top register
    busWrite(3'd4, 16'h0030);
    busWrite(3'd3, 16'h5010);
    busWrite(3'd0, 16'h500F);
    busWrite(3'd5, 16'h0007);
    busWrite(3'd4, 16'h0031);
    cycles(1);
    expectReg(3'd0, 16'h5010, "R11 at top");
    cycles(1);
    expectReg(3'd0, 16'h0000, "R11 wrapped");
    expectReg(3'd5, 16'h0001, "R11 ovf");
    busWrite(3'd4, 16'h0030);

    // R12 double-buffered compare in PWM mode
    busWrite(3'd4, 16'h0000);
    busWrite(3'd1, 16'h0050);
    busWrite(3'd2, 16'h3000);
    busWrite(3'd4, 16'h0030);
    busWrite(3'd3, 16'h0100);
    busWrite(3'd1, 16'h0020);
    busWrite(3'd0, 16'h001F);
    busWrite(3'd5, 16'h0007);
    busWrite(3'd4, 16'h0031);
    cycles(1);
    expectReg(3'd0, 16'h0020, "R12 count");
    expectReg(3'd5, 16'h0000, "R12 buffered no match");
    busWrite(3'd0, 16'h00FF);
    cycles(2);
    expectReg(3'd0, 16'h0000, "R12 wrap");
    cycles(32);
    expectReg(3'd0, 16'h0020, "R12 count after load");
    expectReg(3'd5, 16'h0003, "R12 loaded match");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule